// File: doc/BRIEF.md
# Self-Modifying Code Conflict Detector

This block keeps the instruction side of a core consistent when a program rewrites its own code. It runs two checks side by side, every cycle. The first watches executed stores: each store's physical page number is looked up in a table of translation entries, and every entry carries a marker saying that code from its page currently sits in the instruction cache. A store that lands on a marked page produces a request to invalidate the cached code.

The second check watches instruction fetches. The line address of each fetch is compared against two small queues of pending stores. One queue holds stores that are still speculative and the other holds committed stores waiting to be combined and written out. A hit on a speculative store asks the front end to fetch again. A hit on a committed store asks for a full pipeline flush, and a re-fetch follows one cycle later. The surrounding logic fills and clears the code markers and the queue entries through simple indexed update ports. Address translation, the caches and the flush machinery live elsewhere.

Top module: `smc_guard`

## Requirements
- R1: After synchronous reset, all three request outputs are low, and every code marker and every queue valid bit is clear, so no store or fetch produces a request until new fills or queue writes arrive.
- R2: A fill event records a page number in the indexed table entry and sets its code marker. A store whose page number (address shifted right by PAGE_SHIFT) equals the page of a marked entry raises `code_wr_o` for exactly the cycle after the store.
- R3: A page-invalidate clears the indexed entry's marker. When a fill and an invalidate target the same index in one cycle, the marker ends up clear.
- R4: A store whose page matches no marked entry gives no `code_wr_o`, and `code_wr_o` stays low in any cycle that follows a cycle without a store.
- R5: A fetch whose line address (address shifted right by LINE_SHIFT) equals a valid speculative-queue entry, with no committed-queue hit, raises `refetch_o` in the following cycle and leaves `flush_o` low.
- R6: A fetch whose line address equals a valid committed-queue entry raises `flush_o` in the following cycle, and `refetch_o` rises in the cycle after that unless a new flush is issued then.
- R7: `flush_o` and `refetch_o` are never high in the same cycle. A fetch that hits both queues yields only the flush, followed by the re-fetch.
- R8: A cleared queue entry produces no hit. When a write and a clear target the same queue index in one cycle, the entry ends up invalid.
- R9: The store check and the fetch check are independent: a store hit and a fetch hit in the same cycle both produce their requests in the next cycle.
- R10: Each check uses the table and queue state from before the current cycle's updates, so a fill or queue write in the same cycle as a matching store or fetch does not cause a hit for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_vld | input | 1 | An executed store is presented |
| st_pa | input | PA_W | Physical address of the store |
| fill_vld | input | 1 | Code from a page was cached: mark entry |
| fill_idx | input | log2(TLB_ENTRIES) | Table entry to mark |
| fill_page | input | PA_W-PAGE_SHIFT | Page number recorded in the entry |
| inval_vld | input | 1 | Clear the marker of an entry |
| inval_idx | input | log2(TLB_ENTRIES) | Entry whose marker is cleared |
| fe_vld | input | 1 | An instruction fetch is presented |
| fe_pa | input | PA_W | Fetch address |
| sq_wr | input | 1 | Write a speculative-queue entry |
| sq_wr_idx | input | log2(Q_DEPTH) | Speculative entry written |
| sq_wr_line | input | PA_W-LINE_SHIFT | Line address stored |
| sq_clr | input | 1 | Invalidate a speculative-queue entry |
| sq_clr_idx | input | log2(Q_DEPTH) | Speculative entry cleared |
| cq_wr | input | 1 | Write a committed-queue entry |
| cq_wr_idx | input | log2(Q_DEPTH) | Committed entry written |
| cq_wr_line | input | PA_W-LINE_SHIFT | Line address stored |
| cq_clr | input | 1 | Invalidate a committed-queue entry |
| cq_clr_idx | input | log2(Q_DEPTH) | Committed entry cleared |
| code_wr_o | output | 1 | Store overwrote cached code: invalidate request |
| flush_o | output | 1 | Pipeline flush request |
| refetch_o | output | 1 | Re-fetch request |

## Verification
The assertions take for granted that the update ports carry in-range indices and that a valid-qualified address is only sampled when its valid is high; they place no limit on how often requests come. The stimulus draws pages and lines from small pools so that hits, misses and collisions between a fill or write and an invalidate or clear on the same index all occur often, while indices stay in range by construction. Directed cases cover same-cycle update and lookup, back-to-back flushes and a fetch that hits both queues.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int unsigned DEF_PA_W       = 32;
  localparam int unsigned DEF_PAGE_SHIFT = 12;
  localparam int unsigned DEF_LINE_SHIFT = 5;
  localparam int unsigned DEF_TLB_ENTRIES = 128;
  localparam int unsigned DEF_Q_DEPTH    = 8;

  // recovery action chosen for a fetch in one cycle
  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_REFETCH = 2'd1,
    ACT_FLUSH   = 2'd2
  } fetch_act_e;
endpackage

// File: rtl/smc_code_tracker.sv
module smc_code_tracker #(
  parameter int unsigned ENTRIES = 128,
  parameter int unsigned PN_W    = 20,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_vld,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [PN_W-1:0]  fill_page,
  input  logic             inval_vld,
  input  logic [IDX_W-1:0] inval_idx,
  input  logic             look_vld,
  input  logic [PN_W-1:0]  look_page,
  output logic             hit
);
  logic [PN_W-1:0]    page_q [ENTRIES];
  logic [ENTRIES-1:0] mark_q;
  logic [ENTRIES-1:0] match;

  // page numbers: plain write port, no reset
  always_ff @(posedge clk) begin
    if (fill_vld) page_q[fill_idx] <= fill_page;
  end

  // markers: invalidate wins over fill on the same index
  always_ff @(posedge clk) begin
    if (rst) begin
      mark_q <= '0;
    end else begin
      if (fill_vld)  mark_q[fill_idx]  <= 1'b1;
      if (inval_vld) mark_q[inval_idx] <= 1'b0;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = mark_q[g] && (page_q[g] == look_page);
  end

  assign hit = look_vld && (|match);

  p_inval_clears_r3: assert property (@(posedge clk) disable iff (rst)
    inval_vld |=> !mark_q[$past(inval_idx)]);

  p_fill_marks_r2: assert property (@(posedge clk) disable iff (rst)
    (fill_vld && !(inval_vld && inval_idx == fill_idx)) |=> mark_q[$past(fill_idx)]);
endmodule

// File: rtl/smc_pend_queue.sv
module smc_pend_queue #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LN_W  = 27,
  localparam int unsigned QI_W = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [QI_W-1:0] wr_idx,
  input  logic [LN_W-1:0] wr_line,
  input  logic            clr,
  input  logic [QI_W-1:0] clr_idx,
  input  logic            look_vld,
  input  logic [LN_W-1:0] look_line,
  output logic            hit
);
  logic [LN_W-1:0]  line_q [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] match;

  always_ff @(posedge clk) begin
    if (wr) line_q[wr_idx] <= wr_line;
  end

  // clear wins over write on the same index
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (wr)  valid_q[wr_idx]  <= 1'b1;
      if (clr) valid_q[clr_idx] <= 1'b0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (line_q[g] == look_line);
  end

  assign hit = look_vld && (|match);

  p_clr_clears_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> !valid_q[$past(clr_idx)]);
endmodule

// File: rtl/smc_req_arb.sv
module smc_req_arb
  import smc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic code_hit,
  input  logic spec_hit,
  input  logic comm_hit,
  output logic code_wr_o,
  output logic flush_o,
  output logic refetch_o
);
  fetch_act_e act;
  logic       pend_q;

  always_comb begin
    if (comm_hit)                act = ACT_FLUSH;
    else if (spec_hit || pend_q) act = ACT_REFETCH;
    else                         act = ACT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_wr_o <= 1'b0;
      flush_o   <= 1'b0;
      refetch_o <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      code_wr_o <= code_hit;
      flush_o   <= (act == ACT_FLUSH);
      refetch_o <= (act == ACT_REFETCH);
      pend_q    <= (act == ACT_FLUSH);
    end
  end

  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(flush_o && refetch_o));

  p_flush_then_refetch_r6: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> (refetch_o || flush_o));
endmodule

// File: rtl/smc_guard.sv
module smc_guard
  import smc_pkg::*;
#(
  parameter int unsigned PA_W        = DEF_PA_W,
  parameter int unsigned PAGE_SHIFT  = DEF_PAGE_SHIFT,
  parameter int unsigned LINE_SHIFT  = DEF_LINE_SHIFT,
  parameter int unsigned TLB_ENTRIES = DEF_TLB_ENTRIES,
  parameter int unsigned Q_DEPTH     = DEF_Q_DEPTH,
  localparam int unsigned PN_W  = PA_W - PAGE_SHIFT,
  localparam int unsigned LN_W  = PA_W - LINE_SHIFT,
  localparam int unsigned IDX_W = $clog2(TLB_ENTRIES),
  localparam int unsigned QI_W  = $clog2(Q_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             st_vld,
  input  logic [PA_W-1:0]  st_pa,
  input  logic             fill_vld,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [PN_W-1:0]  fill_page,
  input  logic             inval_vld,
  input  logic [IDX_W-1:0] inval_idx,
  input  logic             fe_vld,
  input  logic [PA_W-1:0]  fe_pa,
  input  logic             sq_wr,
  input  logic [QI_W-1:0]  sq_wr_idx,
  input  logic [LN_W-1:0]  sq_wr_line,
  input  logic             sq_clr,
  input  logic [QI_W-1:0]  sq_clr_idx,
  input  logic             cq_wr,
  input  logic [QI_W-1:0]  cq_wr_idx,
  input  logic [LN_W-1:0]  cq_wr_line,
  input  logic             cq_clr,
  input  logic [QI_W-1:0]  cq_clr_idx,
  output logic             code_wr_o,
  output logic             flush_o,
  output logic             refetch_o
);
  logic [PN_W-1:0] st_page;
  logic [LN_W-1:0] fe_line;
  logic code_hit, spec_hit, comm_hit;
  logic unused_low_bits;

  assign st_page = st_pa[PA_W-1:PAGE_SHIFT];
  assign fe_line = fe_pa[PA_W-1:LINE_SHIFT];
  assign unused_low_bits = ^{st_pa[PAGE_SHIFT-1:0], fe_pa[LINE_SHIFT-1:0]};

  smc_code_tracker #(.ENTRIES(TLB_ENTRIES), .PN_W(PN_W)) u_track (
    .clk(clk), .rst(rst),
    .fill_vld(fill_vld), .fill_idx(fill_idx), .fill_page(fill_page),
    .inval_vld(inval_vld), .inval_idx(inval_idx),
    .look_vld(st_vld), .look_page(st_page), .hit(code_hit)
  );

  smc_pend_queue #(.DEPTH(Q_DEPTH), .LN_W(LN_W)) u_specq (
    .clk(clk), .rst(rst),
    .wr(sq_wr), .wr_idx(sq_wr_idx), .wr_line(sq_wr_line),
    .clr(sq_clr), .clr_idx(sq_clr_idx),
    .look_vld(fe_vld), .look_line(fe_line), .hit(spec_hit)
  );

  smc_pend_queue #(.DEPTH(Q_DEPTH), .LN_W(LN_W)) u_commq (
    .clk(clk), .rst(rst),
    .wr(cq_wr), .wr_idx(cq_wr_idx), .wr_line(cq_wr_line),
    .clr(cq_clr), .clr_idx(cq_clr_idx),
    .look_vld(fe_vld), .look_line(fe_line), .hit(comm_hit)
  );

  smc_req_arb u_arb (
    .clk(clk), .rst(rst),
    .code_hit(code_hit), .spec_hit(spec_hit), .comm_hit(comm_hit),
    .code_wr_o(code_wr_o), .flush_o(flush_o), .refetch_o(refetch_o)
  );

  p_no_store_no_code_r4: assert property (@(posedge clk) disable iff (rst)
    !st_vld |=> !code_wr_o);

  p_no_fetch_no_flush_r9: assert property (@(posedge clk) disable iff (rst)
    !fe_vld |=> !flush_o);
endmodule

// File: tb/smc_guard_test.sv
module smc_guard_test;
  localparam int PA_W = 32, PS = 12, LS = 5, NE = 128, QD = 8;
  localparam int PN_W = PA_W - PS, LN_W = PA_W - LS;

  logic clk = 0, rst = 1;
  logic st_vld = 0, fill_vld = 0, inval_vld = 0, fe_vld = 0;
  logic [PA_W-1:0] st_pa = '0, fe_pa = '0;
  logic [6:0] fill_idx = '0, inval_idx = '0;
  logic [PN_W-1:0] fill_page = '0;
  logic sq_wr = 0, sq_clr = 0, cq_wr = 0, cq_clr = 0;
  logic [2:0] sq_wr_idx = '0, sq_clr_idx = '0, cq_wr_idx = '0, cq_clr_idx = '0;
  logic [LN_W-1:0] sq_wr_line = '0, cq_wr_line = '0;
  logic code_wr_o, flush_o, refetch_o;

  int total = 0, bad = 0;

  // reference state
  logic [PN_W-1:0] m_page [NE];
  logic [NE-1:0]   m_mark;
  logic [LN_W-1:0] m_sq [QD];
  logic [LN_W-1:0] m_cq [QD];
  logic [QD-1:0]   m_sqv, m_cqv;
  logic            m_pend;

  always #5 clk = ~clk;

  smc_guard uut (
    .clk(clk), .rst(rst), .st_vld(st_vld), .st_pa(st_pa),
    .fill_vld(fill_vld), .fill_idx(fill_idx), .fill_page(fill_page),
    .inval_vld(inval_vld), .inval_idx(inval_idx),
    .fe_vld(fe_vld), .fe_pa(fe_pa),
    .sq_wr(sq_wr), .sq_wr_idx(sq_wr_idx), .sq_wr_line(sq_wr_line),
    .sq_clr(sq_clr), .sq_clr_idx(sq_clr_idx),
    .cq_wr(cq_wr), .cq_wr_idx(cq_wr_idx), .cq_wr_line(cq_wr_line),
    .cq_clr(cq_clr), .cq_clr_idx(cq_clr_idx),
    .code_wr_o(code_wr_o), .flush_o(flush_o), .refetch_o(refetch_o)
  );

  function automatic logic exp_code();
    logic h = 0;
    for (int i = 0; i < NE; i++)
      if (m_mark[i] && m_page[i] == st_pa[PA_W-1:PS]) h = 1;
    return st_vld && h;
  endfunction

  function automatic logic exp_qhit(input logic comm);
    logic h = 0;
    for (int i = 0; i < QD; i++) begin
      if (!comm && m_sqv[i] && m_sq[i] == fe_pa[PA_W-1:LS]) h = 1;
      if (comm && m_cqv[i] && m_cq[i] == fe_pa[PA_W-1:LS]) h = 1;
    end
    return fe_vld && h;
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    st_vld = 0; fill_vld = 0; inval_vld = 0; fe_vld = 0;
    sq_wr = 0; sq_clr = 0; cq_wr = 0; cq_clr = 0;
  endtask

  task automatic model_reset();
    m_mark = '0; m_sqv = '0; m_cqv = '0; m_pend = 0;
    for (int i = 0; i < NE; i++) m_page[i] = '0;
    for (int i = 0; i < QD; i++) begin m_sq[i] = '0; m_cq[i] = '0; end
  endtask

  // one cycle: inputs already set; check outputs one edge later
  task automatic step(input string req);
    logic ec, es, ew, ef, er;
    ec = exp_code(); es = exp_qhit(0); ew = exp_qhit(1);
    ef = ew;
    er = (es || m_pend) && !ew;
    @(posedge clk);
    #1;
    m_pend = ew;
    if (fill_vld) begin m_page[fill_idx] = fill_page; m_mark[fill_idx] = 1; end
    if (inval_vld) m_mark[inval_idx] = 0;
    if (sq_wr) begin m_sq[sq_wr_idx] = sq_wr_line; m_sqv[sq_wr_idx] = 1; end
    if (sq_clr) m_sqv[sq_clr_idx] = 0;
    if (cq_wr) begin m_cq[cq_wr_idx] = cq_wr_line; m_cqv[cq_wr_idx] = 1; end
    if (cq_clr) m_cqv[cq_clr_idx] = 0;
    @(negedge clk);
    chk(req, "code_wr_o", code_wr_o, ec);
    chk(req, "flush_o", flush_o, ef);
    chk(req, "refetch_o", refetch_o, er);
    idle();
  endtask

  function automatic logic [PA_W-1:0] pg(input int p, input int off);
    return (PA_W'(p) << PS) | PA_W'(off);
  endfunction

  function automatic logic [PA_W-1:0] ln(input int l);
    return PA_W'(l) << LS;
  endfunction

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    int pages[4];
    pages = '{'h12, 'h33, 'h44, 'h55};
    seed = $urandom(7);
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: outputs low after reset
    chk("R1", "code_wr_o", code_wr_o, 0);
    chk("R1", "flush_o", flush_o, 0);
    chk("R1", "refetch_o", refetch_o, 0);
    // R1: nothing hits with empty state
    st_vld = 1; st_pa = pg(0, 0); fe_vld = 1; fe_pa = '0; step("R1");

    // R2: fill then store on page
    fill_vld = 1; fill_idx = 5; fill_page = 'h12; step("R2");
    st_vld = 1; st_pa = pg('h12, 'habc); step("R2");
    step("R2");
    // R10: fill and matching store in one cycle
    fill_vld = 1; fill_idx = 9; fill_page = 'h33; st_vld = 1; st_pa = pg('h33, 0); step("R10");
    st_vld = 1; st_pa = pg('h33, 4); step("R10");
    // R3: invalidate, and invalidate winning over fill
    inval_vld = 1; inval_idx = 5; step("R3");
    st_vld = 1; st_pa = pg('h12, 0); step("R3");
    fill_vld = 1; fill_idx = 7; fill_page = 'h44; inval_vld = 1; inval_idx = 7; step("R3");
    st_vld = 1; st_pa = pg('h44, 0); step("R3");
    // R4: unmarked page
    st_vld = 1; st_pa = pg('h99, 0); step("R4");

    // R5: speculative hit
    sq_wr = 1; sq_wr_idx = 2; sq_wr_line = 'h100; step("R5");
    fe_vld = 1; fe_pa = ln('h100); step("R5");
    // R6: committed hit then refetch
    cq_wr = 1; cq_wr_idx = 3; cq_wr_line = 'h200; step("R6");
    fe_vld = 1; fe_pa = ln('h200) | 3; step("R6");
    step("R6");
    // R6: back-to-back flushes
    fe_vld = 1; fe_pa = ln('h200); step("R6");
    fe_vld = 1; fe_pa = ln('h200); step("R6");
    step("R6");
    // R7: both queues hit
    sq_wr = 1; sq_wr_idx = 4; sq_wr_line = 'h300; cq_wr = 1; cq_wr_idx = 4; cq_wr_line = 'h300; step("R7");
    fe_vld = 1; fe_pa = ln('h300); step("R7");
    step("R7");
    // R8: clear, and clear winning over write
    sq_clr = 1; sq_clr_idx = 2; step("R8");
    fe_vld = 1; fe_pa = ln('h100); step("R8");
    cq_wr = 1; cq_wr_idx = 6; cq_wr_line = 'h400; cq_clr = 1; cq_clr_idx = 6; step("R8");
    fe_vld = 1; fe_pa = ln('h400); step("R8");
    // R9: store hit and fetch hit together
    st_vld = 1; st_pa = pg('h33, 8); fe_vld = 1; fe_pa = ln('h200); step("R9");
    step("R9");

    // random mix
    for (int n = 0; n < 600; n++) begin
      st_vld = 1'($urandom % 2); st_pa = pg(pages[$urandom % 4], $urandom % 4096);
      fill_vld = ($urandom % 4) == 0; fill_idx = 7'($urandom % 16); fill_page = PN_W'(pages[$urandom % 4]);
      inval_vld = ($urandom % 5) == 0; inval_idx = 7'($urandom % 16);
      fe_vld = 1'($urandom % 2); fe_pa = ln('h100 + ($urandom % 8)) | ($urandom % 32);
      sq_wr = ($urandom % 3) == 0; sq_wr_idx = 3'($urandom); sq_wr_line = LN_W'('h100 + ($urandom % 8));
      sq_clr = ($urandom % 4) == 0; sq_clr_idx = 3'($urandom);
      cq_wr = ($urandom % 4) == 0; cq_wr_idx = 3'($urandom); cq_wr_line = LN_W'('h100 + ($urandom % 8));
      cq_clr = ($urandom % 3) == 0; cq_clr_idx = 3'($urandom);
      step("R9");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule